// File: doc/BRIEF.md
# Atomic Read-Modify-Write Unit

This unit performs a single indivisible read-modify-write on memory for each accepted request. The requester supplies a byte address, a source operand, an operation selector and a width flag that chooses between a 32-bit word and a 64-bit doubleword. The unit first screens the request. It rejects illegal combinations and misaligned addresses before it touches memory. It then reads the old value, computes the replacement in a separate step, and writes that replacement back. On completion it hands back the old value as the destination result.

The unit drives a single-port memory that uses a request/response handshake. Each request is held until its response arrives, and the response may flag an access fault. Any fault, in either phase, ends the operation with an exception pulse that carries a cause code and the address. No result is delivered in that case.

The sequencer walks a fixed set of named states:

- `S_IDLE` goes to `S_TRAP` on an illegal or misaligned request, and to `S_READ` otherwise.
- `S_READ` goes to `S_TRAP` on a faulting response, and to `S_CALC` on a clean one.
- `S_CALC` always goes to `S_WRITE`.
- `S_WRITE` goes to `S_TRAP` on a faulting response, and to `S_DONE` on a clean one.
- `S_DONE` and `S_TRAP` each return to `S_IDLE` after one cycle.

Top module: `amo_unit`

## Requirements
- R1: The operation selector is encoded as follows: 0 swap, 1 add, 2 and, 3 or, 4 xor, 5 signed min, 6 signed max, 7 unsigned min, 8 unsigned max. The written value is derived from the old memory value and the source operand (swap writes the source operand).
- R2: `result` carries the pre-operation memory value during the single cycle in which `done` is high, and is zero in every other cycle.
- R3: A word operation (`req_dword`=0) uses only bits 31:0 of the source operand. It works on the 32-bit lane selected by address bit 2: lane 0 is bits 31:0 with strobe 0x0F, and lane 1 is bits 63:32 with strobe 0xF0. The other lane of the doubleword is left unchanged. The result is the old word sign-extended from bit 31, including for the unsigned min and max operations.
- R4: Signed min/max compare as two's-complement numbers of the operation width. Unsigned min/max compare as unsigned numbers of that width.
- R5: A word address with bits 1:0 nonzero, or a doubleword address with bits 2:0 nonzero, raises an exception with cause 6 and `exc_addr` equal to the request address. No memory request is issued.
- R6: A doubleword request while `cfg_rv64`=0, or a selector above 8, raises cause 2 with no memory request. This check takes priority over the alignment check. Word requests remain legal when `cfg_rv64`=0.
- R7: A faulting read response raises cause 7 with the request address. No write is issued.
- R8: A faulting write response raises cause 7 with the request address, and no `done` pulse is given.
- R9: Each successful operation issues exactly one read followed by exactly one write to the request address. Each memory request is held, with its address and direction unchanged, until its response arrives.
- R10: `busy` is high from the edge that accepts a request until the cycle after the `done` or exception pulse. Requests presented while busy are ignored.
- R11: `done` and `exc_valid` are never high together, and each is a one-cycle pulse.
- R12: While in reset, `busy`, `done`, `exc_valid` and `mem_req_valid` are low, and `result` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_rv64 | input | 1 | Enables doubleword operations |
| req_valid | input | 1 | Request strobe, taken only while idle |
| req_addr | input | ADDR_W | Byte address |
| req_src | input | XLEN | Source operand |
| req_op | input | 4 | Operation selector |
| req_dword | input | 1 | 1 = 64-bit, 0 = 32-bit |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Success pulse |
| result | output | XLEN | Old memory value, valid with done |
| exc_valid | output | 1 | Exception pulse |
| exc_cause | output | 4 | Exception cause code |
| exc_addr | output | ADDR_W | Address of the failed operation |
| mem_req_valid | output | 1 | Memory request |
| mem_req_we | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | ADDR_W | Memory byte address |
| mem_req_wdata | output | XLEN | Write data, lane-replicated for words |
| mem_req_strb | output | XLEN/8 | Byte strobe |
| mem_rsp_valid | input | 1 | Memory response |
| mem_rsp_fault | input | 1 | Access fault flag on the response |
| mem_rsp_rdata | input | XLEN | Read data |

## Verification
The assertions rely on the memory answering each request exactly once and never raising `mem_rsp_valid` without an outstanding request. The bench memory model meets this by responding one cycle after it sees a request and then dropping the response for a cycle. The assertions also rely on `req_valid` being driven only between clock edges. The bench changes every input at the falling edge. Because faults are injected only by doubleword index inside that same memory model, every fault the unit sees is tied to a real outstanding access.

// File: rtl/amo_pkg.sv
`timescale 1ns/1ps
package amo_pkg;

    typedef enum logic [3:0] {
        OP_SWAP = 4'd0,
        OP_ADD  = 4'd1,
        OP_AND  = 4'd2,
        OP_OR   = 4'd3,
        OP_XOR  = 4'd4,
        OP_MIN  = 4'd5,
        OP_MAX  = 4'd6,
        OP_MINU = 4'd7,
        OP_MAXU = 4'd8
    } amo_op_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_READ,
        S_CALC,
        S_WRITE,
        S_DONE,
        S_TRAP
    } amo_state_e;

    localparam logic [3:0] CAUSE_ILLEGAL  = 4'd2;
    localparam logic [3:0] CAUSE_MISALIGN = 4'd6;
    localparam logic [3:0] CAUSE_FAULT    = 4'd7;

endpackage

// File: rtl/amo_alu.sv
`timescale 1ns/1ps
module amo_alu
    import amo_pkg::*;
#(
    parameter  int W    = 64,
    localparam int HALF = W / 2
) (
    input  logic [3:0]   op,
    input  logic         dword,
    input  logic [W-1:0] old_val,
    input  logic [W-1:0] src_val,
    output logic [W-1:0] new_val
);

    logic [W-1:0] a_s, b_s, a_u, b_u, raw;
    logic         s_lt, u_lt;

    always_comb begin
        a_s  = dword ? old_val : {{HALF{old_val[HALF-1]}}, old_val[HALF-1:0]};
        b_s  = dword ? src_val : {{HALF{src_val[HALF-1]}}, src_val[HALF-1:0]};
        a_u  = dword ? old_val : {{HALF{1'b0}}, old_val[HALF-1:0]};
        b_u  = dword ? src_val : {{HALF{1'b0}}, src_val[HALF-1:0]};
        s_lt = $signed(a_s) < $signed(b_s);
        u_lt = a_u < b_u;
        case (amo_op_e'(op))
            OP_SWAP: raw = src_val;
            OP_ADD:  raw = old_val + src_val;
            OP_AND:  raw = old_val & src_val;
            OP_OR:   raw = old_val | src_val;
            OP_XOR:  raw = old_val ^ src_val;
            OP_MIN:  raw = s_lt ? old_val : src_val;
            OP_MAX:  raw = s_lt ? src_val : old_val;
            OP_MINU: raw = u_lt ? old_val : src_val;
            OP_MAXU: raw = u_lt ? src_val : old_val;
            default: raw = old_val;
        endcase
        new_val = dword ? raw : {{HALF{1'b0}}, raw[HALF-1:0]};
    end

endmodule

// File: rtl/amo_lane.sv
`timescale 1ns/1ps
module amo_lane #(
    parameter  int W    = 64,
    localparam int HALF = W / 2,
    localparam int SB   = W / 8,
    localparam int HB   = SB / 2
) (
    input  logic          dword,
    input  logic          lane_hi,
    input  logic [W-1:0]  rdata,
    input  logic [W-1:0]  new_val,
    output logic [W-1:0]  old_sized,
    output logic [W-1:0]  wdata,
    output logic [SB-1:0] strb
);

    always_comb begin
        if (dword) begin
            old_sized = rdata;
            wdata     = new_val;
            strb      = {SB{1'b1}};
        end else begin
            old_sized = {{HALF{1'b0}}, (lane_hi ? rdata[W-1:HALF] : rdata[HALF-1:0])};
            wdata     = {2{new_val[HALF-1:0]}};
            strb      = lane_hi ? {{HB{1'b1}}, {HB{1'b0}}} : {{HB{1'b0}}, {HB{1'b1}}};
        end
    end

endmodule

// File: rtl/amo_unit.sv
`timescale 1ns/1ps
module amo_unit
    import amo_pkg::*;
#(
    parameter  int XLEN   = 64,
    parameter  int ADDR_W = 32,
    localparam int STRB_W = XLEN / 8,
    localparam int HALF   = XLEN / 2,
    localparam int OFS_W  = $clog2(STRB_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_rv64,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [XLEN-1:0]   req_src,
    input  logic [3:0]        req_op,
    input  logic              req_dword,
    output logic              busy,
    output logic              done,
    output logic [XLEN-1:0]   result,
    output logic              exc_valid,
    output logic [3:0]        exc_cause,
    output logic [ADDR_W-1:0] exc_addr,
    output logic              mem_req_valid,
    output logic              mem_req_we,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic [XLEN-1:0]   mem_req_wdata,
    output logic [STRB_W-1:0] mem_req_strb,
    input  logic              mem_rsp_valid,
    input  logic              mem_rsp_fault,
    input  logic [XLEN-1:0]   mem_rsp_rdata
);

    amo_state_e        state_q, state_d;
    logic [ADDR_W-1:0] addr_q;
    logic [XLEN-1:0]   src_q, old_q, new_q;
    logic [3:0]        op_q, cause_q;
    logic              dword_q;

    logic              accept, illegal, misaligned;
    logic [XLEN-1:0]   rd_sized, alu_out, lane_wdata;
    logic [STRB_W-1:0] lane_strb;

    assign accept     = req_valid && (state_q == S_IDLE);
    assign illegal    = (req_dword && !cfg_rv64) || (req_op > OP_MAXU);
    assign misaligned = req_dword ? (|req_addr[OFS_W-1:0]) : (|req_addr[OFS_W-2:0]);

    amo_lane #(.W(XLEN)) u_lane (
        .dword     (dword_q),
        .lane_hi   (addr_q[OFS_W-1]),
        .rdata     (mem_rsp_rdata),
        .new_val   (new_q),
        .old_sized (rd_sized),
        .wdata     (lane_wdata),
        .strb      (lane_strb)
    );

    amo_alu #(.W(XLEN)) u_alu (
        .op      (op_q),
        .dword   (dword_q),
        .old_val (old_q),
        .src_val (src_q),
        .new_val (alu_out)
    );

    // next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (accept) state_d = (illegal || misaligned) ? S_TRAP : S_READ;
            S_READ:  if (mem_rsp_valid) state_d = mem_rsp_fault ? S_TRAP : S_CALC;
            S_CALC:  state_d = S_WRITE;
            S_WRITE: if (mem_rsp_valid) state_d = mem_rsp_fault ? S_TRAP : S_DONE;
            S_DONE:  state_d = S_IDLE;
            S_TRAP:  state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // captured operands and intermediate values
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            src_q   <= '0;
            old_q   <= '0;
            new_q   <= '0;
            op_q    <= '0;
            cause_q <= '0;
            dword_q <= 1'b0;
        end else begin
            if (accept) begin
                addr_q  <= req_addr;
                src_q   <= req_src;
                op_q    <= req_op;
                dword_q <= req_dword;
                cause_q <= illegal ? CAUSE_ILLEGAL : CAUSE_MISALIGN;
            end
            if (state_q == S_READ && mem_rsp_valid) begin
                old_q <= rd_sized;
                if (mem_rsp_fault) cause_q <= CAUSE_FAULT;
            end
            if (state_q == S_CALC) new_q <= alu_out;
            if (state_q == S_WRITE && mem_rsp_valid && mem_rsp_fault) cause_q <= CAUSE_FAULT;
        end
    end

    // outputs by state
    always_comb begin
        busy          = (state_q != S_IDLE);
        mem_req_valid = (state_q == S_READ) || (state_q == S_WRITE);
        mem_req_we    = (state_q == S_WRITE);
        mem_req_addr  = addr_q;
        mem_req_wdata = lane_wdata;
        mem_req_strb  = mem_req_valid ? lane_strb : '0;
        done          = (state_q == S_DONE);
        result        = '0;
        exc_valid     = (state_q == S_TRAP);
        exc_cause     = '0;
        exc_addr      = '0;
        if (state_q == S_DONE)
            result = dword_q ? old_q : {{HALF{old_q[HALF-1]}}, old_q[HALF-1:0]};
        if (state_q == S_TRAP) begin
            exc_cause = cause_q;
            exc_addr  = addr_q;
        end
    end

endmodule

// File: rtl/amo_unit_chk.sv
`timescale 1ns/1ps
module amo_unit_chk
    import amo_pkg::*;
#(
    parameter int XLEN   = 64,
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              done,
    input logic [XLEN-1:0]   result,
    input logic              exc_valid,
    input logic [3:0]        exc_cause,
    input logic              mem_req_valid,
    input logic              mem_req_we,
    input logic [ADDR_W-1:0] mem_req_addr,
    input logic              mem_rsp_valid
);

    // R11
    not_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && exc_valid));

    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R11
    exc_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exc_valid |=> !exc_valid);

    // R10
    idle_after_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done || exc_valid) |=> !busy);

    // R9
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_rsp_valid) |=>
            (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_we)));

    // R9
    req_in_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> busy);

    // R2
    result_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> (result == '0));

    // R5
    cause_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exc_valid |-> (exc_cause == CAUSE_ILLEGAL || exc_cause == CAUSE_MISALIGN
                       || exc_cause == CAUSE_FAULT));

endmodule

bind amo_unit amo_unit_chk #(.XLEN(XLEN), .ADDR_W(ADDR_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .busy          (busy),
    .done          (done),
    .result        (result),
    .exc_valid     (exc_valid),
    .exc_cause     (exc_cause),
    .mem_req_valid (mem_req_valid),
    .mem_req_we    (mem_req_we),
    .mem_req_addr  (mem_req_addr),
    .mem_rsp_valid (mem_rsp_valid)
);

// File: tb/sim_amo_unit.sv
`timescale 1ns/1ps
module sim_amo_unit;

    localparam int XLEN   = 64;
    localparam int ADDR_W = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic              cfg_rv64 = 1'b1, req_valid = 1'b0, req_dword = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [XLEN-1:0]   req_src = '0;
    logic [3:0]        req_op = '0;
    logic              busy, done, exc_valid, mem_req_valid, mem_req_we;
    logic [XLEN-1:0]   result, mem_req_wdata;
    logic [3:0]        exc_cause;
    logic [ADDR_W-1:0] exc_addr, mem_req_addr;
    logic [7:0]        mem_req_strb;
    logic              mem_rsp_valid, mem_rsp_fault;
    logic [XLEN-1:0]   mem_rsp_rdata;

    amo_unit u0 (
        .clk(clk), .rst_n(rst_n), .cfg_rv64(cfg_rv64),
        .req_valid(req_valid), .req_addr(req_addr), .req_src(req_src),
        .req_op(req_op), .req_dword(req_dword),
        .busy(busy), .done(done), .result(result),
        .exc_valid(exc_valid), .exc_cause(exc_cause), .exc_addr(exc_addr),
        .mem_req_valid(mem_req_valid), .mem_req_we(mem_req_we),
        .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
        .mem_req_strb(mem_req_strb), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_fault(mem_rsp_fault), .mem_rsp_rdata(mem_rsp_rdata)
    );

    // behavioural memory: 16 doublewords, one-cycle response
    logic [63:0] mem [0:15];
    int          rd_cnt = 0, wr_cnt = 0;
    int          flt_rd = -1, flt_wr = -1;
    logic        pl_en = 1'b0;
    int          pl_idx = 0;
    logic [63:0] pl_data = '0;
    int          m_idx;
    logic [63:0] m_word;

    always @(posedge clk) begin
        if (pl_en) mem[pl_idx] <= pl_data;
        if (!rst_n) begin
            mem_rsp_valid <= 1'b0;
            mem_rsp_fault <= 1'b0;
            mem_rsp_rdata <= '0;
        end else if (mem_req_valid && !mem_rsp_valid) begin
            m_idx = int'(mem_req_addr[6:3]);
            mem_rsp_valid <= 1'b1;
            if (mem_req_we) begin
                wr_cnt <= wr_cnt + 1;
                mem_rsp_fault <= (m_idx == flt_wr);
                if (m_idx != flt_wr) begin
                    m_word = mem[m_idx];
                    for (int b = 0; b < 8; b++)
                        if (mem_req_strb[b]) m_word[8*b +: 8] = mem_req_wdata[8*b +: 8];
                    mem[m_idx] <= m_word;
                end
            end else begin
                rd_cnt <= rd_cnt + 1;
                mem_rsp_fault <= (m_idx == flt_rd);
                mem_rsp_rdata <= mem[m_idx];
            end
        end else begin
            mem_rsp_valid <= 1'b0;
            mem_rsp_fault <= 1'b0;
        end
    end

    int n_chk = 0, n_fail = 0;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(5.0 * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=%h expected=%h", 64'd0, 64'd1);
        summary();
    end

    function automatic logic [63:0] ref_new(input int op, input bit dw,
                                           input logic [63:0] o, input logic [63:0] s);
        longint          so, ss;
        longint unsigned uo, us;
        logic [63:0]     r;
        if (dw) begin
            so = o; ss = s; uo = o; us = s;
        end else begin
            so = longint'($signed(o[31:0]));
            ss = longint'($signed(s[31:0]));
            uo = {32'd0, o[31:0]};
            us = {32'd0, s[31:0]};
        end
        case (op)
            0: r = s;
            1: r = o + s;
            2: r = o & s;
            3: r = o | s;
            4: r = o ^ s;
            5: r = (so < ss) ? o : s;
            6: r = (so > ss) ? o : s;
            7: r = (uo < us) ? o : s;
            default: r = (uo > us) ? o : s;
        endcase
        if (!dw) r = {32'd0, r[31:0]};
        return r;
    endfunction

    task automatic preload(input int idx, input logic [63:0] d);
        @(negedge clk);
        pl_en = 1'b1; pl_idx = idx; pl_data = d;
        @(negedge clk);
        pl_en = 1'b0;
    endtask

    bit          g_done, g_exc, g_busy_ok;
    int          g_pulses, g_nrd, g_nwr;
    logic [63:0] g_res;
    logic [3:0]  g_cause;
    logic [31:0] g_eaddr;

    task automatic run_op(input int op, input bit dw, input logic [31:0] addr,
                          input logic [63:0] src, input bit poke);
        int r0, w0;
        r0 = rd_cnt; w0 = wr_cnt;
        g_done = 0; g_exc = 0; g_pulses = 0; g_busy_ok = 1;
        g_res = '0; g_cause = '0; g_eaddr = '0;
        @(negedge clk);
        req_valid = 1'b1; req_op = 4'(op); req_dword = dw; req_addr = addr; req_src = src;
        @(negedge clk);
        req_valid = 1'b0;
        if (poke) begin
            req_valid = 1'b1; req_addr = 32'h60; req_op = 4'd0;
            req_dword = 1'b1; req_src = '1;
        end
        for (int i = 0; i < 40; i++) begin
            if (!busy) g_busy_ok = 0;
            if (done || exc_valid) begin
                g_pulses++;
                g_done = done; g_exc = exc_valid; g_res = result;
                g_cause = exc_cause; g_eaddr = exc_addr;
            end
            @(negedge clk);
            req_valid = 1'b0;
            if (g_pulses > 0) break;
        end
        if (busy || done || exc_valid) g_busy_ok = 0;
        g_nrd = rd_cnt - r0;
        g_nwr = wr_cnt - w0;
    endtask

    task automatic do_full(input int op, input bit dw, input logic [31:0] addr,
                           input logic [63:0] init, input logic [63:0] src,
                           input bit poke, input string tag);
        int          idx;
        logic [63:0] old_l, exp_res, nv, exp_mem;
        idx = int'(addr[6:3]);
        preload(idx, init);
        run_op(op, dw, addr, src, poke);
        old_l   = dw ? init : (addr[2] ? {32'd0, init[63:32]} : {32'd0, init[31:0]});
        exp_res = dw ? old_l : {{32{old_l[31]}}, old_l[31:0]};
        nv      = ref_new(op, dw, old_l, src);
        exp_mem = dw ? nv : (addr[2] ? {nv[31:0], init[31:0]} : {init[63:32], nv[31:0]});
        chk(g_done && !g_exc, {tag, " done"}, {62'd0, g_exc, g_done}, 64'd1);
        chk(g_res === exp_res, {tag, " old value result"}, g_res, exp_res);
        chk(mem[idx] === exp_mem, {tag, " memory after"}, mem[idx], exp_mem);
        // R9: one read, one write
        chk(g_nrd == 1 && g_nwr == 1, "R9 access count", 64'(g_nrd * 16 + g_nwr), 64'h11);
        // R10 / R11: busy span and single pulse
        chk(g_busy_ok && g_pulses == 1, "R10 busy span", 64'(g_pulses), 64'd1);
    endtask

    task automatic do_trap(input int op, input bit dw, input logic [31:0] addr,
                           input logic [3:0] exp_cause, input int exp_rd, input int exp_wr,
                           input string tag);
        int          idx;
        logic [63:0] init;
        idx  = int'(addr[6:3]);
        init = 64'h5A5A_1234_A5A5_4321;
        preload(idx, init);
        run_op(op, dw, addr, 64'hFFFF_0000_FFFF_0001, 1'b0);
        chk(g_exc && !g_done, {tag, " exception"}, {62'd0, g_done, g_exc}, 64'd1);
        chk(g_cause == exp_cause, {tag, " cause"}, 64'(g_cause), 64'(exp_cause));
        chk(g_eaddr == addr, {tag, " address"}, 64'(g_eaddr), 64'(addr));
        chk(g_nrd == exp_rd && g_nwr == exp_wr, {tag, " accesses"},
            64'(g_nrd * 16 + g_nwr), 64'(exp_rd * 16 + exp_wr));
        chk(mem[idx] === init, {tag, " memory untouched"}, mem[idx], init);
        chk(g_busy_ok && g_pulses == 1, "R11 single exception pulse", 64'(g_pulses), 64'd1);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        // R12: reset state
        chk(!busy && !done && !exc_valid && !mem_req_valid, "R12 reset outputs",
            {60'd0, busy, done, exc_valid, mem_req_valid}, 64'd0);
        chk(result == '0, "R12 reset result", result, 64'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1 / R4: doubleword operations, top bit set in the old value
        for (int op = 0; op < 9; op++)
            do_full(op, 1'b1, 32'h10, 64'h8000_0000_0000_0005, 64'h0000_0000_0000_0003,
                    1'b0, (op >= 5) ? "R4" : "R1");
        for (int op = 0; op < 9; op++)
            do_full(op, 1'b1, 32'h18, 64'h7FFF_FFFF_FFFF_FFFE, 64'hFFFF_FFFF_FFFF_FFFF,
                    1'b0, (op >= 5) ? "R4" : "R1");
        // R3: word operations, upper lane, negative old word
        for (int op = 0; op < 9; op++)
            do_full(op, 1'b0, 32'h24, 64'hAAAA_BBBB_0000_1111, 64'h1234_5678_0000_0010,
                    1'b0, "R3");
        // R3: word operations, lower lane, upper source bits ignored
        for (int op = 0; op < 9; op++)
            do_full(op, 1'b0, 32'h28, 64'hCCCC_DDDD_7FFF_FFFF, 64'hFFFF_FFFF_8000_0000,
                    1'b0, "R3");

        // R2: result quiet while idle
        @(negedge clk);
        chk(result == '0, "R2 idle result", result, 64'd0);

        // R5: misalignment
        do_trap(1, 1'b0, 32'h32, 4'd6, 0, 0, "R5 word");
        do_trap(1, 1'b1, 32'h34, 4'd6, 0, 0, "R5 dword");
        do_full(1, 1'b0, 32'h3C, 64'h0000_0001_0000_0002, 64'd5, 1'b0, "R5 aligned word");

        // R6: illegal requests take priority over alignment
        cfg_rv64 = 1'b0;
        do_trap(0, 1'b1, 32'h40, 4'd2, 0, 0, "R6 dword off");
        do_trap(0, 1'b1, 32'h43, 4'd2, 0, 0, "R6 priority");
        do_full(8, 1'b0, 32'h48, 64'h0000_0000_FFFF_FFF0, 64'd7, 1'b0, "R6 word legal");
        cfg_rv64 = 1'b1;
        do_trap(9, 1'b0, 32'h50, 4'd2, 0, 0, "R6 bad op");
        do_trap(15, 1'b0, 32'h51, 4'd2, 0, 0, "R6 bad op misaligned");

        // R7: read fault
        flt_rd = 6;
        do_trap(1, 1'b0, 32'h34, 4'd7, 1, 0, "R7");
        flt_rd = -1;
        // R8: write fault
        flt_wr = 5;
        do_trap(1, 1'b1, 32'h28, 4'd7, 1, 1, "R8");
        flt_wr = -1;

        // R10: request during busy ignored
        preload(12, 64'h0BAD_F00D_0BAD_F00D);
        do_full(4, 1'b1, 32'h08, 64'h1111_2222_3333_4444, 64'hFFFF_0000_FFFF_0000, 1'b1, "R10");
        chk(mem[12] === 64'h0BAD_F00D_0BAD_F00D, "R10 ignored request", mem[12],
            64'h0BAD_F00D_0BAD_F00D);

        repeat (3) @(negedge clk);
        summary();
    end

endmodule